// File: doc/BRIEF.md
# Multi-Master Doorbell Unit

A bank of doorbells through which up to 32 requesting masters signal a receiving agent. Each doorbell has one owner. A master rings a doorbell by writing to that doorbell's ring register over a 32-bit memory-mapped port. The port carries a master-ID sideband, and the ring sets the bit at that master's ID in the doorbell's latch register. The owner programs a per-master permission mask. The active view is the latch ANDed with the mask. The owner's interrupt output stays high while any active bit is set.

The owner services the doorbell in three steps. It reads the active view, handles each master it finds there, and writes the same value back to the active register. That write clears those bits. A master whose permission bit is clear can still ring. Its bit is held in the latch, but it raises no interrupt until the owner grants permission. Reads return data in the same cycle as the request.

Top module: `mm_doorbell_unit`

## Requirements
- R1: After reset every latch and mask register reads 0 and every `irq_o` bit is low.
- R2: A write to offset 0x0 of a doorbell with `wdata_i[0]`=1 sets bit `mid_i` of that doorbell's latch register (offset 0x8), whether or not that bit is permitted. A write to offset 0x0 with `wdata_i[0]`=0 changes nothing.
- R3: Offset 0xC reads the latch ANDed with the mask. Offset 0x0 always reads 0.
- R4: A write to offset 0x4 replaces the whole 32-bit mask, and the mask reads back at offset 0x4.
- R5: `irq_o[b]` is high exactly when doorbell b has a nonzero active value. It changes in the cycle after the write edge that causes the change. When a mask write grants a master that has already rung, the interrupt rises at once.
- R6: A write to offset 0xC clears each latch bit that is 1 in `wdata_i` and also set in the mask. Latch bits that are not permitted are kept.
- R7: A write to offset 0x8 has no effect.
- R8: Address bits [11:8] select the doorbell, using a stride of 0x100. Bits [3:2] select the register. An access to a doorbell index at or above the number of doorbells changes nothing and reads 0.
- R9: A write to one doorbell never changes the state or the interrupt of another doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| mid_i | input | 5 | ID of the requesting master |
| rdata_o | output | 32 | Read data, valid in the same cycle as a read |
| irq_o | output | 4 | One level interrupt per doorbell |

## Verification
A wrong latch bit or mask bit shows up on `irq_o` in the cycle after the write that caused it, provided that bit is permitted. The bench therefore compares every interrupt on every clock against a behavioural model. A latch error hidden behind a clear mask bit shows only at the ports. It is caught by reading offset 0x8, or later when a mask write exposes it. For that reason the sequences read the latch register after each ring that is not permitted. They also read all registers after clears, after ignored writes, and after accesses outside the doorbell range.

// File: rtl/db_pkg.sv
package db_pkg;
  typedef enum logic [1:0] {
    REG_RING   = 2'd0,
    REG_MASK   = 2'd1,
    REG_LATCH  = 2'd2,
    REG_ACTIVE = 2'd3
  } db_reg_e;
endpackage

// File: rtl/db_decode.sv
module db_decode
  import db_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BELL_LSB  = 8,
  parameter int NUM_BELLS = 4
) (
  input  logic                 req_i,
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BELLS-1:0] sel_o,
  output db_reg_e              reg_o
);
  localparam int IDX_W = ADDR_W - BELL_LSB;

  logic [IDX_W-1:0] idx;
  assign idx   = addr_i[ADDR_W-1:BELL_LSB];
  assign reg_o = db_reg_e'(addr_i[3:2]);

  for (genvar b = 0; b < NUM_BELLS; b++) begin : g_sel
    assign sel_o[b] = req_i && (idx == IDX_W'(b));
  end
endmodule

// File: rtl/db_bell.sv
module db_bell
  import db_pkg::*;
#(
  parameter int NUM_MASTERS = 32,
  parameter int MID_W       = $clog2(NUM_MASTERS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sel_i,
  input  logic                   we_i,
  input  db_reg_e                reg_i,
  input  logic [NUM_MASTERS-1:0] wdata_i,
  input  logic [MID_W-1:0]       mid_i,
  output logic [NUM_MASTERS-1:0] rdata_o,
  output logic                   irq_o
);
  logic [NUM_MASTERS-1:0] raw_q, en_q, set_v, clr_v, act;
  logic ring, clr_hit, mask_wr;

  assign ring    = sel_i && we_i && (reg_i == REG_RING) && wdata_i[0];
  assign clr_hit = sel_i && we_i && (reg_i == REG_ACTIVE);
  assign mask_wr = sel_i && we_i && (reg_i == REG_MASK);
  assign set_v   = ring ? (NUM_MASTERS'(1) << mid_i) : '0;
  assign clr_v   = clr_hit ? (wdata_i & en_q) : '0;
  assign act     = raw_q & en_q;

  // a ring in the same cycle as a clear of the same bit wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
    end else begin
      raw_q <= (raw_q & ~clr_v) | set_v;
      if (mask_wr) en_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      unique case (reg_i)
        REG_RING:   rdata_o = '0;
        REG_MASK:   rdata_o = en_q;
        REG_LATCH:  rdata_o = raw_q;
        REG_ACTIVE: rdata_o = act;
      endcase
    end
  end

  assign irq_o = |act;

  AST_RING_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ring |=> raw_q[$past(mid_i)]); // R2
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && !ring) |=> ((raw_q & $past(wdata_i & en_q)) == '0)); // R6
  AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> (en_q == $past(wdata_i))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i) |=> ($stable(raw_q) && $stable(en_q))); // R9
endmodule

// File: rtl/mm_doorbell_unit.sv
module mm_doorbell_unit
  import db_pkg::*;
#(
  parameter int NUM_BELLS   = 4,
  parameter int NUM_MASTERS = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int STRIDE      = 256,
  parameter int MID_W       = $clog2(NUM_MASTERS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic [MID_W-1:0]     mid_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic [NUM_BELLS-1:0] irq_o
);
  localparam int BELL_LSB = $clog2(STRIDE);

  logic [NUM_BELLS-1:0]   sel;
  db_reg_e                reg_sel;
  logic [NUM_MASTERS-1:0] bell_rd [NUM_BELLS];
  logic [NUM_MASTERS-1:0] rd_or;

  db_decode #(
    .ADDR_W(ADDR_W), .BELL_LSB(BELL_LSB), .NUM_BELLS(NUM_BELLS)
  ) i_decode (
    .req_i(req_i), .addr_i(addr_i), .sel_o(sel), .reg_o(reg_sel)
  );

  for (genvar b = 0; b < NUM_BELLS; b++) begin : g_bell
    db_bell #(.NUM_MASTERS(NUM_MASTERS), .MID_W(MID_W)) i_bell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel[b]),
      .we_i    (we_i),
      .reg_i   (reg_sel),
      .wdata_i (wdata_i[NUM_MASTERS-1:0]),
      .mid_i   (mid_i),
      .rdata_o (bell_rd[b]),
      .irq_o   (irq_o[b])
    );
  end

  always_comb begin
    rd_or = '0;
    for (int b = 0; b < NUM_BELLS; b++) rd_or |= bell_rd[b];
  end

  assign rdata_o = (req_i && !we_i) ? DATA_W'(rd_or) : '0;

  AST_ONE_BELL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel)); // R8
  AST_QUIET_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |-> (rdata_o == '0)); // R3
  AST_RESET_IRQ: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (irq_o == '0)); // R1
endmodule

// File: tb/test_mm_doorbell_unit.sv
module test_mm_doorbell_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [4:0]  mid = '0;
  logic [31:0] rdata;
  logic [NB-1:0] irq;

  int total = 0, bad = 0;
  logic [31:0] m_raw [NB];
  logic [31:0] m_en  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_doorbell_unit i_mm_doorbell_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .mid_i(mid), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R5 R9: interrupts compared against the model on every clock
  always @(negedge clk) if (rst_n) begin
    for (int b = 0; b < NB; b++)
      check("R5 irq", 32'(irq[b]), 32'(|(m_raw[b] & m_en[b])));
  end

  task automatic wr(int a, logic [31:0] d, int m);
    int b, r;
    @(negedge clk);
    req = 1; we = 1; addr = 12'(a); wdata = d; mid = 5'(m);
    @(posedge clk);
    b = a >> 8; r = (a >> 2) & 3;
    if (b < NB) begin
      case (r)
        0: if (d[0]) m_raw[b][m] = 1'b1;
        1: m_en[b] = d;
        3: m_raw[b] = m_raw[b] & ~(d & m_en[b]);
        default: ;
      endcase
    end
    #1 req = 0; we = 0;
  endtask

  task automatic rd(string tag, int a);
    int b, r;
    logic [31:0] exp;
    @(negedge clk);
    req = 1; we = 0; addr = 12'(a);
    #1;
    b = a >> 8; r = (a >> 2) & 3;
    exp = 0;
    if (b < NB) begin
      case (r)
        1: exp = m_en[b];
        2: exp = m_raw[b];
        3: exp = m_raw[b] & m_en[b];
        default: exp = 0;
      endcase
    end
    check(tag, rdata, exp);
    req = 0;
  endtask

  task automatic rd_all(string tag);
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 4; r++) rd(tag, b*256 + r*4);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int b = 0; b < NB; b++) begin m_raw[b] = 0; m_en[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd_all("R1 reset");

    // R2: ring without permission lands in latch only
    wr(12'h008 & 12'h000, 32'h1, 7);
    rd("R2 latch", 12'h008);
    rd("R3 active masked", 12'h00C);
    wr(12'h000, 32'h2, 9);               // R2 bit0=0 no effect
    rd("R2 bit0 zero", 12'h008);
    rd("R3 ring reads 0", 12'h000);

    // R5: granting an already rung master raises irq at once
    wr(12'h004, 32'h0000_0080, 0);
    rd("R4 mask readback", 12'h004);
    rd("R5 active", 12'h00C);

    // R2 R6: more masters, partial permission, clear
    wr(12'h000, 32'h1, 0);
    wr(12'h000, 32'h1, 31);
    wr(12'h000, 32'h1, 3);
    wr(12'h004, 32'h8000_0081, 0);
    rd("R3 active mix", 12'h00C);
    wr(12'h00C, 32'hFFFF_FFFF, 0);
    rd("R6 latch kept unpermitted", 12'h008);
    wr(12'h004, 32'h0000_0008, 0);
    wr(12'h00C, 32'h0000_0000, 0);
    rd("R6 zero clear", 12'h008);
    wr(12'h00C, 32'h0000_0008, 0);
    rd("R6 cleared", 12'h008);

    // R7: latch writes ignored
    wr(12'h000, 32'h1, 12);
    wr(12'h008, 32'h0000_0000, 0);
    rd("R7 latch write ignored", 12'h008);

    // R9: other bells independent
    wr(12'h200, 32'h1, 5);
    wr(12'h204, 32'h0000_0020, 0);
    wr(12'h300, 32'h1, 20);
    wr(12'h304, 32'hFFFF_FFFF, 0);
    rd_all("R9 bells");
    wr(12'h30C, 32'h0010_0000, 0);
    rd_all("R9 after clear");

    // R8: outside the doorbell range
    wr(12'h400, 32'h1, 1);
    wr(12'hF04, 32'hFFFF_FFFF, 0);
    rd("R8 out of range", 12'h404);
    rd("R8 out of range", 12'hF08);
    rd_all("R8 untouched");

    // R4: mask overwrite
    wr(12'h104, 32'hA5A5_5A5A, 0);
    wr(12'h104, 32'h0000_0001, 0);
    rd("R4 mask overwrite", 12'h104);

    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule